// File: doc/BRIEF.md
# Posit Quire Multiply-Accumulate Unit

This block is an exact accumulator for posit arithmetic. It holds one wide two's-complement fixed-point register, the quire, sized for a chosen posit width. It takes posits that an upstream stage has already unpacked into fields: sign, zero flag, NaR flag, signed scale and fraction without the hidden bit. Three operations act on the register. A load replaces the register with one posit. A multiply-accumulate adds the exact product of two posits. A readout turns the register back into sign, scale, fraction and a sticky flag, which a downstream normalizer uses for round-to-nearest-even.

No rounding happens between accumulations. The binary point is placed so that the square of the smallest posit lands exactly on the least significant bit. The bits above the square of the largest posit act as guard bits that absorb carries. Operations enter through a valid/ready handshake and pass through a three-stage pipeline: term alignment, quire update, then readout register. Only readouts produce output beats.

Top module: `pquire_mac`

## Requirements
- R1: With the defaults (N=16, ES=1, 12 fraction bits, scale range ±28) the quire is N·N/2 = 128 bits. Its LSB weighs 2^-56, so the square of the smallest posit (scale -28 times scale -28) reads out exactly, with scale -56, fraction 0 and sticky 0.
- R2: Opcode 0 (load) replaces the quire with operand A, signed and aligned by its scale, and clears the NaR flag unless A is NaR. A load of a zero operand gives a zero quire. Operand B is ignored.
- R3: Opcode 1 (multiply-accumulate) adds (1+fa)·(1+fb)·2^(sa+sb) to the quire, with sign sa_sign XOR sb_sign, and does no rounding.
- R4: A multiply-accumulate with a zero operand, and no NaR operand, leaves the quire unchanged.
- R5: A NaR operand in a multiply-accumulate sets the NaR flag. The flag then survives later multiply-accumulates and readouts until the next load. A load of a NaR operand also sets it.
- R6: Opcodes 2 and 3 (readout) report the quire's sign and its magnitude. The scale is the position of the magnitude's leading one minus 56. The 16-bit fraction holds the bits just below the leading one, most significant bit first.
- R7: The sticky output is the OR of every magnitude bit below the kept 16-bit fraction.
- R8: A zero quire reads out as zero=1 with sign, nar, scale, fraction and sticky all 0. A NaR quire reads out as nar=1 with every other field 0.
- R9: A readout does not change the quire, so two readouts in a row give the same result.
- R10: An operation is taken on a clock edge where in_valid and in_ready are both high. A readout's result appears with out_valid two edges after the edge that takes it. While out_valid is high and out_ready is low, the outputs hold and in_ready is low. After reset, out_valid=0 and in_ready=1.
- R11: The guard bits let sums beyond the largest square accumulate without wrap-around. Four products of scale 28 times scale 28 read out with scale 58.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_op | input | 2 | 0 load, 1 multiply-accumulate, 2/3 readout |
| a_sign | input | 1 | Operand A sign |
| a_zero | input | 1 | Operand A is zero |
| a_nar | input | 1 | Operand A is NaR |
| a_scale | input | SW (7) | Operand A signed scale |
| a_frac | input | FW (12) | Operand A fraction, hidden bit omitted |
| b_sign | input | 1 | Operand B sign |
| b_zero | input | 1 | Operand B is zero |
| b_nar | input | 1 | Operand B is NaR |
| b_scale | input | SW (7) | Operand B signed scale |
| b_frac | input | FW (12) | Operand B fraction, hidden bit omitted |
| out_valid | output | 1 | Readout result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Quire sign |
| out_zero | output | 1 | Quire is zero |
| out_nar | output | 1 | Quire is NaR |
| out_scale | output | QSW (8) | Signed scale of the leading one |
| out_frac | output | RD_FRAC (16) | Bits below the leading one |
| out_sticky | output | 1 | OR of all bits below out_frac |

## Verification
The quire can only be seen through readouts, so a corrupted accumulator bit or a wrongly placed term shows up at the next readout, two cycles after it is taken. A single-bit error below the kept fraction shows only in the sticky flag. A lost NaR flag shows as an ordinary number where nar=1 is expected. The check therefore issues a readout after every group of updates and compares all six fields against a reference quire in the bench. Backpressure faults show up at once as outputs that change, or a non-zero in_ready, while out_ready is low.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [1:0] {
    PQ_LOAD  = 2'd0,
    PQ_MAC   = 2'd1,
    PQ_READ  = 2'd2,
    PQ_READ2 = 2'd3
  } pq_op_e;

  function automatic logic pq_is_read(pq_op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/pq_term.sv
// Builds the aligned two's-complement term for a load or a multiply-accumulate.
module pq_term #(
  parameter int FW    = 12,
  parameter int SW    = 7,
  parameter int QW    = 128,
  parameter int QFRAC = 56
) (
  input  pq_pkg::pq_op_e     op,
  input  logic               a_sign,
  input  logic               a_zero,
  input  logic               a_nar,
  input  logic [SW-1:0]      a_scale,
  input  logic [FW-1:0]      a_frac,
  input  logic               b_sign,
  input  logic               b_zero,
  input  logic               b_nar,
  input  logic [SW-1:0]      b_scale,
  input  logic [FW-1:0]      b_frac,
  output logic [QW-1:0]      term,
  output logic               term_nar,
  output logic               term_null
);
  localparam int PW   = 2 * (FW + 1);
  localparam int EXTW = QW + 2 * FW;

  // Product has its binary point 2*FW bits up; move it to quire bit QFRAC+psc.
  function automatic logic [QW-1:0] place(logic [PW-1:0] prod, logic signed [SW:0] psc,
                                          logic neg);
    int sh;
    logic [QW-1:0] mag;
    sh  = QFRAC + int'(psc);
    mag = QW'((EXTW'(prod) << sh) >> (2 * FW));
    return neg ? (~mag + 1'b1) : mag;
  endfunction

  logic              is_load;
  logic              eb_sign, eb_zero, eb_nar;
  logic [SW-1:0]     eb_scale;
  logic [FW-1:0]     eb_frac;
  logic [PW-1:0]     prod;
  logic signed [SW:0] psc;

  always_comb begin
    is_load  = (op == pq_pkg::PQ_LOAD);
    // A load is a product with 1.0: sign 0, scale 0, fraction 0.
    eb_sign  = is_load ? 1'b0 : b_sign;
    eb_zero  = is_load ? 1'b0 : b_zero;
    eb_nar   = is_load ? 1'b0 : b_nar;
    eb_scale = is_load ? '0 : b_scale;
    eb_frac  = is_load ? '0 : b_frac;
    term_nar  = a_nar | eb_nar;
    term_null = !term_nar && (a_zero | eb_zero);
    prod = PW'({1'b1, a_frac}) * PW'({1'b1, eb_frac});
    psc  = $signed({a_scale[SW-1], a_scale}) + $signed({eb_scale[SW-1], eb_scale});
    term = (term_nar | term_null) ? '0 : place(prod, psc, a_sign ^ eb_sign);
  end
endmodule

// File: rtl/pq_quire.sv
// The accumulator register, its NaR flag and the readout snapshot.
module pq_quire #(
  parameter int QW = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           in_vld,
  input  pq_pkg::pq_op_e in_op,
  input  logic [QW-1:0]  term,
  input  logic           term_nar,
  output logic [QW-1:0]  snap,
  output logic           snap_nar,
  output logic           snap_vld
);
  logic [QW-1:0] quire;
  logic          q_nar;
  logic          wr_load, wr_mac, rd_take;

  assign wr_load = adv && in_vld && (in_op == pq_pkg::PQ_LOAD);
  assign wr_mac  = adv && in_vld && (in_op == pq_pkg::PQ_MAC);
  assign rd_take = in_vld && pq_pkg::pq_is_read(in_op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quire    <= '0;
      q_nar    <= 1'b0;
      snap     <= '0;
      snap_nar <= 1'b0;
      snap_vld <= 1'b0;
    end else begin
      if (wr_load) begin
        quire <= term;
        q_nar <= term_nar;
      end else if (wr_mac) begin
        quire <= quire + term;
        q_nar <= q_nar | term_nar;
      end
      if (adv) begin
        snap_vld <= rd_take;
        if (rd_take) begin
          snap     <= quire;
          snap_nar <= q_nar;
        end
      end
    end
  end

  // R9
  quire_only_by_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_load || wr_mac) |=> $stable(quire));
  // R5
  nar_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_nar && !wr_load) |=> q_nar);
  // R2
  load_clears_nar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load && !term_nar) |=> !q_nar);
  // R4
  null_term_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mac && !term_nar && term == '0) |=> $stable(quire));
endmodule

// File: rtl/pq_readout.sv
// Leading-one search over the whole quire, fraction pick and sticky flag.
module pq_readout #(
  parameter int QW    = 128,
  parameter int QFRAC = 56,
  parameter int QSW   = 8,
  parameter int RF    = 16
) (
  input  logic [QW-1:0]  quire,
  input  logic           nar,
  output logic           r_sign,
  output logic           r_zero,
  output logic           r_nar,
  output logic [QSW-1:0] r_scale,
  output logic [RF-1:0]  r_frac,
  output logic           r_sticky
);
  logic [QW-1:0] mag;
  logic [QW-2:0] below;
  int            pos;
  logic          empty;

  always_comb begin
    mag   = quire[QW-1] ? (~quire + 1'b1) : quire;
    empty = (mag == '0);
    pos   = 0;
    for (int i = 0; i < QW; i++) begin
      if (mag[i]) pos = i;
    end
    // Leading one pushed out of the top; what is left is the fraction.
    below = (QW-1)'(mag << (QW - 1 - pos));
    if (nar || empty) begin
      r_sign   = 1'b0;
      r_zero   = !nar;
      r_nar    = nar;
      r_scale  = '0;
      r_frac   = '0;
      r_sticky = 1'b0;
    end else begin
      r_sign   = quire[QW-1];
      r_zero   = 1'b0;
      r_nar    = 1'b0;
      r_scale  = QSW'(pos - QFRAC);
      r_frac   = below[QW-2 -: RF];
      r_sticky = |below[QW-2-RF:0];
    end
  end
endmodule

// File: rtl/pquire_mac.sv
module pquire_mac #(
  parameter int N       = 16,
  parameter int ES      = 1,
  parameter int RD_FRAC = 16,
  localparam int FW     = N - 3 - ES,
  localparam int MAXS   = (N - 2) << ES,
  localparam int SW     = $clog2(MAXS + 1) + 2,
  localparam int QW     = N * N / 2,        // R1: quire width
  localparam int QFRAC  = 2 * MAXS,         // R1: LSB weight is minpos squared
  localparam int QSW    = $clog2(QW) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_op,
  input  logic           a_sign,
  input  logic           a_zero,
  input  logic           a_nar,
  input  logic [SW-1:0]  a_scale,
  input  logic [FW-1:0]  a_frac,
  input  logic           b_sign,
  input  logic           b_zero,
  input  logic           b_nar,
  input  logic [SW-1:0]  b_scale,
  input  logic [FW-1:0]  b_frac,
  output logic           out_valid,
  input  logic           out_ready,
  output logic           out_sign,
  output logic           out_zero,
  output logic           out_nar,
  output logic [QSW-1:0] out_scale,
  output logic [RD_FRAC-1:0] out_frac,
  output logic           out_sticky
);
  logic            stall, adv;
  logic [QW-1:0]   t_term;
  logic            t_nar, t_null;
  logic            s1_vld, s1_nar;
  pq_pkg::pq_op_e  s1_op;
  logic [QW-1:0]   s1_term;
  logic [QW-1:0]   snap;
  logic            snap_nar, snap_vld;
  logic            ro_sign, ro_zero, ro_nar, ro_sticky;
  logic [QSW-1:0]  ro_scale;
  logic [RD_FRAC-1:0] ro_frac;

  assign stall    = out_valid && !out_ready;
  assign adv      = !stall;
  assign in_ready = adv;

  pq_term #(.FW(FW), .SW(SW), .QW(QW), .QFRAC(QFRAC)) u_term (
    .op(pq_pkg::pq_op_e'(in_op)),
    .a_sign(a_sign), .a_zero(a_zero), .a_nar(a_nar), .a_scale(a_scale), .a_frac(a_frac),
    .b_sign(b_sign), .b_zero(b_zero), .b_nar(b_nar), .b_scale(b_scale), .b_frac(b_frac),
    .term(t_term), .term_nar(t_nar), .term_null(t_null)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_op   <= pq_pkg::PQ_LOAD;
      s1_term <= '0;
      s1_nar  <= 1'b0;
    end else if (adv) begin
      s1_vld  <= in_valid;
      s1_op   <= pq_pkg::pq_op_e'(in_op);
      s1_term <= t_term;
      s1_nar  <= t_nar;
    end
  end

  pq_quire #(.QW(QW)) u_quire (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_vld(s1_vld), .in_op(s1_op),
    .term(s1_term), .term_nar(s1_nar),
    .snap(snap), .snap_nar(snap_nar), .snap_vld(snap_vld)
  );

  pq_readout #(.QW(QW), .QFRAC(QFRAC), .QSW(QSW), .RF(RD_FRAC)) u_readout (
    .quire(snap), .nar(snap_nar),
    .r_sign(ro_sign), .r_zero(ro_zero), .r_nar(ro_nar),
    .r_scale(ro_scale), .r_frac(ro_frac), .r_sticky(ro_sticky)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sign   <= 1'b0;
      out_zero   <= 1'b0;
      out_nar    <= 1'b0;
      out_scale  <= '0;
      out_frac   <= '0;
      out_sticky <= 1'b0;
    end else if (adv) begin
      out_valid  <= snap_vld;
      out_sign   <= ro_sign;
      out_zero   <= ro_zero;
      out_nar    <= ro_nar;
      out_scale  <= ro_scale;
      out_frac   <= ro_frac;
      out_sticky <= ro_sticky;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable({out_sign, out_zero, out_nar,
                                                       out_scale, out_frac, out_sticky}));
  // R8
  zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (!out_sign && !out_nar && out_frac == '0 && !out_sticky
                                 && out_scale == '0));
  // R8
  nar_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nar) |-> (!out_sign && !out_zero && out_frac == '0 && !out_sticky));
  // R1
  scale_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zero && !out_nar) |-> ($signed(out_scale) >= -QFRAC));
endmodule

// File: tb/test_pquire_mac.sv
module test_pquire_mac;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, in_ready, out_ready, out_valid;
  logic [1:0] in_op;
  logic a_sign, a_zero, a_nar, b_sign, b_zero, b_nar;
  logic [6:0] a_scale, b_scale;
  logic [11:0] a_frac, b_frac;
  logic out_sign, out_zero, out_nar, out_sticky;
  logic [7:0] out_scale;
  logic [15:0] out_frac;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [127:0] mq;
  logic mnar;

  pquire_mac i_pquire_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .a_sign(a_sign), .a_zero(a_zero), .a_nar(a_nar), .a_scale(a_scale), .a_frac(a_frac),
    .b_sign(b_sign), .b_zero(b_zero), .b_nar(b_nar), .b_scale(b_scale), .b_frac(b_frac),
    .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign), .out_zero(out_zero),
    .out_nar(out_nar), .out_scale(out_scale), .out_frac(out_frac), .out_sticky(out_sticky)
  );

  function automatic logic [45:0] mk(logic [1:0] op, logic as, logic az, logic an,
                                     logic [6:0] asc, logic [11:0] af, logic bs, logic bz,
                                     logic bn, logic [6:0] bsc, logic [11:0] bf);
    return {op, as, az, an, asc, af, bs, bz, bn, bsc, bf};
  endfunction

  // Stimulus vectors; read entries are compared with the reference quire.
  localparam logic [45:0] VEC [15] = '{
    mk(2'd0, 1'b0, 1'b0, 1'b0, 7'd3,   12'h800, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000),
    mk(2'd1, 1'b0, 1'b0, 1'b0, 7'h7E,  12'h400, 1'b1, 1'b0, 1'b0, 7'd5,   12'hC00),
    mk(2'd1, 1'b1, 1'b0, 1'b0, 7'd10,  12'h123, 1'b1, 1'b0, 1'b0, 7'h79,  12'hFFF),
    mk(2'd2, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000),
    mk(2'd1, 1'b0, 1'b0, 1'b0, 7'h64,  12'h000, 1'b0, 1'b0, 1'b0, 7'h64,  12'h000),
    mk(2'd3, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000),
    mk(2'd0, 1'b1, 1'b0, 1'b0, 7'd0,   12'h001, 1'b1, 1'b1, 1'b1, 7'd9,   12'hFFF),
    mk(2'd1, 1'b0, 1'b0, 1'b0, 7'd1,   12'h555, 1'b0, 1'b0, 1'b0, 7'd1,   12'hAAA),
    mk(2'd2, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000),
    mk(2'd1, 1'b0, 1'b1, 1'b0, 7'd4,   12'h0F0, 1'b0, 1'b0, 1'b0, 7'd2,   12'h00F),
    mk(2'd2, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000),
    mk(2'd1, 1'b1, 1'b0, 1'b0, 7'd27,  12'h7FF, 1'b0, 1'b0, 1'b0, 7'h65,  12'h001),
    mk(2'd2, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000),
    mk(2'd0, 1'b0, 1'b1, 1'b0, 7'd5,   12'h3AB, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000),
    mk(2'd2, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000, 1'b0, 1'b0, 1'b0, 7'd0,   12'h000)
  };

  // Reference quire: value times 2^56, two's complement in 128 bits.
  task automatic model_apply(logic [45:0] v);
    logic [127:0] sig, val;
    int s;
    if (v[45]) return;
    if (v[45:44] == 2'd0) begin
      mnar = v[41];
      if (v[41] || v[42]) mq = '0;
      else begin
        sig = 128'({1'b1, v[33:22]});
        s = 44 + int'($signed(v[40:34]));
        val = sig << s;
        mq = v[43] ? (128'd0 - val) : val;
      end
    end else begin
      if (v[41] || v[19]) mnar = 1'b1;
      else if (!(v[42] || v[20])) begin
        sig = 128'({1'b1, v[33:22]}) * 128'({1'b1, v[11:0]});
        s = 32 + int'($signed(v[40:34])) + int'($signed(v[18:12]));
        val = (s >= 0) ? (sig << s) : (sig >> (-s));
        mq = (v[43] ^ v[21]) ? (mq - val) : (mq + val);
      end
    end
  endtask

  function automatic logic [27:0] model_read();
    logic [127:0] mag;
    logic [15:0] f;
    logic st, sg;
    int p;
    if (mnar) return {1'b0, 1'b0, 1'b1, 25'd0};
    if (mq == '0) return {1'b0, 1'b1, 1'b0, 25'd0};
    sg = mq[127];
    mag = sg ? (128'd0 - mq) : mq;
    p = -1;
    for (int i = 127; i >= 0; i--) if (p < 0 && mag[i]) p = i;
    f = '0;
    for (int j = 0; j < 16; j++) if (p - 1 - j >= 0) f[15-j] = mag[p-1-j];
    st = 1'b0;
    for (int i = 0; i < p - 16; i++) st = st | mag[i];
    return {sg, 1'b0, 1'b0, 8'(p - 56), f, st};
  endfunction

  task automatic check(string tag, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] outv();
    return {out_sign, out_zero, out_nar, out_scale, out_frac, out_sticky};
  endfunction

  task automatic send(logic [45:0] v);
    @(negedge clk);
    {in_op, a_sign, a_zero, a_nar, a_scale, a_frac,
     b_sign, b_zero, b_nar, b_scale, b_frac} = v;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    model_apply(v);
  endtask

  task automatic read_check(string tag, logic [27:0] exp);
    int n;
    send(mk(2'd2, 1'b0, 1'b0, 1'b0, 7'd0, 12'h0, 1'b0, 1'b0, 1'b0, 7'd0, 12'h0));
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!out_valid && n < 8);
    check(tag, outv(), exp);
  endtask

  function automatic logic [45:0] ld(logic s, logic [6:0] sc, logic [11:0] f);
    return mk(2'd0, s, 1'b0, 1'b0, sc, f, 1'b0, 1'b0, 1'b0, 7'd0, 12'h0);
  endfunction

  function automatic logic [45:0] mac(logic as, logic [6:0] asc, logic [11:0] af,
                                      logic bs, logic [6:0] bsc, logic [11:0] bf);
    return mk(2'd1, as, 1'b0, 1'b0, asc, af, bs, 1'b0, 1'b0, bsc, bf);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_op = 2'd0;
    {a_sign, a_zero, a_nar, a_scale, a_frac} = '0;
    {b_sign, b_zero, b_nar, b_scale, b_frac} = '0;
    mq = '0; mnar = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset", {26'd0, out_valid, in_ready}, {26'd0, 1'b0, 1'b1});

    // R3 R6 R7 table walk against the reference quire
    for (int k = 0; k < 15; k++) begin
      if (VEC[k][45]) read_check("R3/R6/R7 table", model_read());
      else send(VEC[k]);
    end

    // R3: 1.0 + 1.5*1.5 = 3.25
    send(ld(1'b0, 7'd0, 12'h0));
    send(mac(1'b0, 7'd0, 12'h800, 1'b0, 7'd0, 12'h800));
    read_check("R3 exact product", {3'b000, 8'd1, 16'hA000, 1'b0});
    // R9 second readout unchanged
    read_check("R9 repeat read", {3'b000, 8'd1, 16'hA000, 1'b0});

    // R7 sticky from a far-below bit
    send(ld(1'b0, 7'd20, 12'h0));
    send(mac(1'b0, 7'h6C, 12'h0, 1'b0, 7'd0, 12'h0));
    read_check("R7 sticky", {3'b000, 8'd20, 16'h0000, 1'b1});

    // R1 minpos squared at the LSB, then maxpos squared on top
    send(mk(2'd0, 1'b0, 1'b1, 1'b0, 7'd0, 12'h0, 1'b0, 1'b0, 1'b0, 7'd0, 12'h0));
    send(mac(1'b0, 7'h64, 12'h0, 1'b0, 7'h64, 12'h0));
    read_check("R1 minpos squared", {3'b000, 8'hC8, 16'h0000, 1'b0});
    send(mac(1'b0, 7'd28, 12'h0, 1'b0, 7'd28, 12'h0));
    read_check("R1 full span", {3'b000, 8'd56, 16'h0000, 1'b1});

    // R11 guard bits
    send(mk(2'd0, 1'b0, 1'b1, 1'b0, 7'd0, 12'h0, 1'b0, 1'b0, 1'b0, 7'd0, 12'h0));
    for (int k = 0; k < 4; k++) send(mac(1'b0, 7'd28, 12'h0, 1'b0, 7'd28, 12'h0));
    read_check("R11 guard", {3'b000, 8'd58, 16'h0000, 1'b0});

    // R6 negative result: -1.0 + 0.5 = -0.5
    send(ld(1'b1, 7'd0, 12'h0));
    send(mac(1'b0, 7'h7F, 12'h0, 1'b0, 7'd0, 12'h0));
    read_check("R6 negative", {3'b100, 8'hFF, 16'h0000, 1'b0});

    // R8 exact cancellation
    send(ld(1'b0, 7'd0, 12'h0));
    send(mac(1'b1, 7'd0, 12'h0, 1'b0, 7'd0, 12'h0));
    read_check("R8 zero quire", {3'b010, 25'd0});

    // R4 zero operand leaves quire
    send(ld(1'b0, 7'd0, 12'h0));
    send(mk(2'd1, 1'b0, 1'b0, 1'b0, 7'd9, 12'h321, 1'b1, 1'b1, 1'b0, 7'd7, 12'h444));
    read_check("R4 zero operand", {3'b000, 8'd0, 16'h0000, 1'b0});

    // R5 NaR sticky until load; R2 load clears it
    send(mk(2'd1, 1'b0, 1'b0, 1'b1, 7'd0, 12'h0, 1'b0, 1'b0, 1'b0, 7'd0, 12'h0));
    read_check("R5 nar set", {3'b001, 25'd0});
    send(mac(1'b0, 7'd2, 12'h0, 1'b0, 7'd1, 12'h0));
    read_check("R5 nar kept", {3'b001, 25'd0});
    send(mk(2'd0, 1'b0, 1'b0, 1'b0, 7'd1, 12'h0, 1'b0, 1'b0, 1'b1, 7'd0, 12'h0));
    read_check("R2 load clears nar", {3'b000, 8'd1, 16'h0000, 1'b0});
    send(mk(2'd0, 1'b0, 1'b0, 1'b1, 7'd0, 12'h0, 1'b0, 1'b0, 1'b0, 7'd0, 12'h0));
    read_check("R5 load nar", {3'b001, 25'd0});

    // R10 latency and backpressure
    send(ld(1'b0, 7'd0, 12'h0));
    out_ready = 1'b0;
    send(mk(2'd2, 1'b0, 1'b0, 1'b0, 7'd0, 12'h0, 1'b0, 1'b0, 1'b0, 7'd0, 12'h0));
    @(negedge clk);
    check("R10 not early", {27'd0, out_valid}, 28'd0);
    @(negedge clk);
    check("R10 not early 2", {27'd0, out_valid}, 28'd0);
    @(negedge clk);
    check("R10 latency", {26'd0, out_valid, in_ready}, {26'd0, 1'b1, 1'b0});
    repeat (3) @(negedge clk);
    check("R10 hold", outv(), {3'b000, 8'd0, 16'h0000, 1'b0});
    check("R10 hold valid", {26'd0, out_valid, in_ready}, {26'd0, 1'b1, 1'b0});
    out_ready = 1'b1;
    @(negedge clk);
    check("R10 drained", {26'd0, out_valid, in_ready}, {26'd0, 1'b0, 1'b1});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule